// File: doc/BRIEF.md
# Multiply-Accumulate Unit with HI/LO Accumulator

This block is a 32-bit integer multiplier for a processor execution stage. It holds a 64-bit accumulator split into a high word and a low word. One opcode loads the accumulator with a product. Two more opcodes add the product to the accumulator or subtract it. A fourth opcode returns only the low 32 bits of the product on a separate result port and leaves the accumulator alone. Operands are treated as signed or unsigned according to a flag.

The cost of an operation depends on the second operand (rt). If rt can be represented in 16 bits, the single shared 33x17 multiplier finishes in one pass. Otherwise it makes two passes, and the unit deasserts `ready` for one cycle so that no new operation can start. The result-port opcode has one extra writeback stage after the multiplier. Because of that stage, a new operation may enter while a result is still on its way to the port.

Top module: `mac_hilo`

## Requirements
- R1: While `rst` is high, and at the first clock after it is released, `hi_out` and `lo_out` read 0, `ready` is 1 and `res_valid` is 0.
- R2: rt counts as short when its bits 31..16 all equal bit 15 (`in_signed`=1) or are all zero (`in_signed`=0). Any other rt counts as long.
- R3: An operation is accepted on a rising edge where `in_valid` and `ready` are both high. Opcode `in_op`=0 loads the full 64-bit product into {`hi_out`,`lo_out`}. The accumulator keeps its old value until the new value appears after the first edge following acceptance (short rt) or the second edge (long rt).
- R4: Opcode `in_op`=1 adds the 64-bit product to {`hi_out`,`lo_out`}, modulo 2^64. The timing is the same as in R3.
- R5: Opcode `in_op`=2 subtracts the 64-bit product from {`hi_out`,`lo_out`}, modulo 2^64. The timing is the same as in R3.
- R6: With `in_signed`=1 both operands are sign-extended before the multiply. With `in_signed`=0 both are zero-extended.
- R7: Opcode `in_op`=3 drives the low 32 product bits onto `res_lo`, with `res_valid` high for exactly one cycle. That cycle follows the second edge after acceptance (short rt) or the third edge (long rt). {`hi_out`,`lo_out`} is left unchanged.
- R8: After a short-rt operation is accepted, `ready` stays high, so a new operation can be accepted on the very next edge. After a long-rt operation is accepted, `ready` is low for exactly one cycle.
- R9: An `in_valid` presented while `ready` is low is ignored and has no effect on the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request |
| in_op | input | 2 | Opcode: 0 load, 1 add, 2 subtract, 3 low word to result port |
| in_signed | input | 1 | 1 = signed operands, 0 = unsigned |
| in_rs | input | 32 | First operand |
| in_rt | input | 32 | Second operand; its width sets the latency |
| ready | output | 1 | Unit can accept an operation this cycle |
| res_valid | output | 1 | One-cycle strobe for `res_lo` |
| res_lo | output | 32 | Low word of the product for opcode 3 |
| hi_out | output | 32 | Accumulator high word |
| lo_out | output | 32 | Accumulator low word |

## Verification
The hardest condition to reach is a clash between a one-pass commit and a new acceptance on the same edge. This happens when short-rt accumulate operations arrive back to back. Each commit must then see the accumulator value left by the previous commit, and the extra stage of the result-port path must carry two consecutive results without merging them. The stimulus creates this by holding `in_valid` high on consecutive edges with short operands. It also presents a request during the single busy cycle of a long operation, to show that the request is dropped. A sweep runs every opcode and both signedness modes over operands chosen around the 16-bit and 32-bit sign boundaries.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int XLEN = 32;
    localparam int HALF = XLEN / 2;
    localparam int EXT  = XLEN + 1;
    localparam int BW   = HALF + 1;
    localparam int PW   = 2 * XLEN;
    localparam int PPW  = EXT + BW;

    typedef enum logic [1:0] {
        MAC_SET = 2'd0,
        MAC_ADD = 2'd1,
        MAC_SUB = 2'd2,
        MAC_LOW = 2'd3
    } mac_op_e;

    typedef struct packed {
        mac_op_e           op;
        logic              sgn;
        logic [XLEN-1:0]   rs;
        logic [XLEN-1:0]   rt;
    } mac_req_t;

    typedef struct packed {
        logic              vld;
        mac_op_e           op;
        logic [PW-1:0]     prod;
    } mac_done_t;

    function automatic logic rt_is_short(input logic [XLEN-1:0] v, input logic sgn);
        if (sgn)
            return v[XLEN-1:HALF] == {HALF{v[HALF-1]}};
        return v[XLEN-1:HALF] == '0;
    endfunction

    function automatic logic [EXT-1:0] widen(input logic [XLEN-1:0] v, input logic sgn);
        return {sgn & v[XLEN-1], v};
    endfunction
endpackage

// File: rtl/mac_engine.sv
module mac_engine
    import mac_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  mac_req_t  req,
    output logic      ready,
    output mac_done_t done
);
    logic              active, last, hi_pass;
    mac_op_e           op_q;
    logic [EXT-1:0]    a_q;
    logic [BW-1:0]     b_q, bhi_q;
    logic [PW-1:0]     part_q;
    logic signed [PPW-1:0] pp;
    logic [PW-1:0]     pp_ext, sum;

    // one shared 33x17 signed multiplier, used once or twice per operation
    assign pp     = $signed({{(PPW-EXT){a_q[EXT-1]}}, a_q}) * $signed({{(PPW-BW){b_q[BW-1]}}, b_q});
    assign pp_ext = {{(PW-PPW){pp[PPW-1]}}, pp};
    assign sum    = part_q + (hi_pass ? (pp_ext << HALF) : pp_ext);

    assign ready     = !active || last;
    assign done.vld  = active && last;
    assign done.op   = op_q;
    assign done.prod = sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            last    <= 1'b0;
            hi_pass <= 1'b0;
            op_q    <= MAC_SET;
            a_q     <= '0;
            b_q     <= '0;
            bhi_q   <= '0;
            part_q  <= '0;
        end else if (start) begin
            active  <= 1'b1;
            hi_pass <= 1'b0;
            op_q    <= req.op;
            a_q     <= widen(req.rs, req.sgn);
            part_q  <= '0;
            bhi_q   <= {req.sgn & req.rt[XLEN-1], req.rt[XLEN-1:HALF]};
            if (rt_is_short(req.rt, req.sgn)) begin
                last <= 1'b1;
                b_q  <= {req.sgn & req.rt[HALF-1], req.rt[HALF-1:0]};
            end else begin
                last <= 1'b0;
                b_q  <= {1'b0, req.rt[HALF-1:0]};
            end
        end else if (active && !last) begin
            part_q  <= sum;
            b_q     <= bhi_q;
            hi_pass <= 1'b1;
            last    <= 1'b1;
        end else if (active) begin
            active <= 1'b0;
        end
    end

    assert_long_busy_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        (start && !rt_is_short(req.rt, req.sgn)) |=> (!ready ##1 ready));
endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  mac_done_t       done,
    output logic [XLEN-1:0] hi,
    output logic [XLEN-1:0] lo
);
    logic [PW-1:0] hilo_q, hilo_d;

    always_comb begin
        case (done.op)
            MAC_SET: hilo_d = done.prod;
            MAC_ADD: hilo_d = hilo_q + done.prod;
            MAC_SUB: hilo_d = hilo_q - done.prod;
            default: hilo_d = hilo_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            hilo_q <= '0;
        else if (done.vld)
            hilo_q <= hilo_d;
    end

    assign hi = hilo_q[PW-1:XLEN];
    assign lo = hilo_q[XLEN-1:0];

    assert_low_keeps_hilo_R7: assert property (@(posedge clk) disable iff (rst)
        (done.vld && done.op == MAC_LOW) |=> $stable(hilo_q));

    assert_hilo_moves_on_commit_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(hilo_q) |-> $past(done.vld));
endmodule

// File: rtl/mac_wb.sv
module mac_wb
    import mac_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            commit,
    input  mac_op_e         op,
    input  logic [XLEN-1:0] prod_lo,
    output logic            res_valid,
    output logic [XLEN-1:0] res_lo
);
    logic            stage_v;
    logic [XLEN-1:0] stage_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_v   <= 1'b0;
            stage_d   <= '0;
            res_valid <= 1'b0;
            res_lo    <= '0;
        end else begin
            stage_v   <= commit && op == MAC_LOW;
            if (commit && op == MAC_LOW)
                stage_d <= prod_lo;
            res_valid <= stage_v;
            if (stage_v)
                res_lo <= stage_d;
        end
    end

    assert_result_two_edges_R7: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(commit && op == MAC_LOW, 2));
endmodule

// File: rtl/mac_hilo.sv
module mac_hilo
    import mac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [1:0]  in_op,
    input  logic        in_signed,
    input  logic [31:0] in_rs,
    input  logic [31:0] in_rt,
    output logic        ready,
    output logic        res_valid,
    output logic [31:0] res_lo,
    output logic [31:0] hi_out,
    output logic [31:0] lo_out
);
    mac_req_t  req;
    mac_done_t done;
    logic      start;

    assign req.op  = mac_op_e'(in_op);
    assign req.sgn = in_signed;
    assign req.rs  = in_rs;
    assign req.rt  = in_rt;
    assign start   = in_valid && ready;

    mac_engine u_engine (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .req   (req),
        .ready (ready),
        .done  (done)
    );

    mac_accum u_accum (
        .clk  (clk),
        .rst  (rst),
        .done (done),
        .hi   (hi_out),
        .lo   (lo_out)
    );

    mac_wb u_wb (
        .clk       (clk),
        .rst       (rst),
        .commit    (done.vld),
        .op        (done.op),
        .prod_lo   (done.prod[XLEN-1:0]),
        .res_valid (res_valid),
        .res_lo    (res_lo)
    );

    assert_short_keeps_ready_R8: assert property (@(posedge clk) disable iff (rst)
        (start && rt_is_short(in_rt, in_signed)) |=> ready);
endmodule

// File: tb/mac_hilo_bench.sv
module mac_hilo_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'd0;
    logic        in_signed = 1'b0;
    logic [31:0] in_rs = '0;
    logic [31:0] in_rt = '0;
    logic        ready, res_valid;
    logic [31:0] res_lo, hi_out, lo_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [63:0] model = '0;

    always #5 clk = ~clk;

    mac_hilo u_mac_hilo (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_signed(in_signed), .in_rs(in_rs), .in_rt(in_rt),
        .ready(ready), .res_valid(res_valid), .res_lo(res_lo),
        .hi_out(hi_out), .lo_out(lo_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_prod(input logic sgn, input logic [31:0] a, input logic [31:0] b);
        logic [65:0] ea, eb, p;
        ea = sgn ? {{34{a[31]}}, a} : {34'b0, a};
        eb = sgn ? {{34{b[31]}}, b} : {34'b0, b};
        p  = ea * eb;
        return p[63:0];
    endfunction

    // R2: short rt classification
    function automatic bit ref_short(input logic sgn, input logic [31:0] b);
        return sgn ? (b[31:16] == {16{b[15]}}) : (b[31:16] == 16'h0);
    endfunction

    function automatic logic [63:0] hilo();
        return {hi_out, lo_out};
    endfunction

    task automatic run_op(input logic [1:0] op, input logic sgn, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] p, want;
        bit sh;
        int lat;
        p  = ref_prod(sgn, a, b);
        sh = ref_short(sgn, b);
        @(negedge clk);
        while (!ready) @(negedge clk);
        in_valid = 1'b1; in_op = op; in_signed = sgn; in_rs = a; in_rt = b;
        @(negedge clk);
        in_valid = 1'b0;
        check(ready == sh, "R8/R2 ready after issue", {63'b0, ready}, {63'b0, sh});
        if (op != 2'd3) begin
            case (op)
                2'd0:    want = p;
                2'd1:    want = model + p;
                default: want = model - p;
            endcase
            check(hilo() == model, "R3 accumulator held before commit", hilo(), model);
            repeat (sh ? 1 : 2) @(negedge clk);
            if (op == 2'd0)      check(hilo() == want, sgn ? "R3 R6 load signed" : "R3 R6 load unsigned", hilo(), want);
            else if (op == 2'd1) check(hilo() == want, "R4 add", hilo(), want);
            else                 check(hilo() == want, "R5 subtract", hilo(), want);
            model = want;
        end else begin
            lat = sh ? 2 : 3;
            repeat (lat - 1) @(negedge clk);
            check(res_valid == 1'b0, "R7 strobe early", {63'b0, res_valid}, 64'd0);
            @(negedge clk);
            check(res_valid && res_lo == p[31:0], "R7 R6 low word", {31'b0, res_valid, res_lo}, {31'b0, 1'b1, p[31:0]});
            @(negedge clk);
            check(res_valid == 1'b0, "R7 single pulse", {63'b0, res_valid}, 64'd0);
            check(hilo() == model, "R7 accumulator untouched", hilo(), model);
        end
    endtask

    logic [31:0] vals [10] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h0000_7FFF, 32'h0000_8000,
                               32'hFFFF_8000, 32'h0001_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'h1234_5678};

    initial begin
        logic [63:0] pa, pb;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(hilo() == 64'd0, "R1 accumulator", hilo(), 64'd0);
        check(ready == 1'b1 && res_valid == 1'b0, "R1 ready/res_valid", {62'b0, ready, res_valid}, 64'd2);
        rst = 1'b0;
        @(negedge clk);
        check(hilo() == 64'd0 && ready && !res_valid, "R1 after release", {hi_out, lo_out}, 64'd0);

        // sweep every opcode, both signedness modes (R6), boundary operands (R2)
        for (int op = 0; op < 4; op++)
            for (int s = 0; s < 2; s++)
                for (int i = 0; i < 10; i++)
                    for (int j = 0; j < 10; j++)
                        run_op(op[1:0], s[0], vals[i], vals[j]);

        // R8: back-to-back short accumulate
        pa = ref_prod(1'b1, 32'h0000_1234, 32'h0000_0F00);
        pb = ref_prod(1'b1, 32'hFFFF_FF00, 32'hFFFF_9000);
        @(negedge clk);
        while (!ready) @(negedge clk);
        in_valid = 1'b1; in_op = 2'd1; in_signed = 1'b1; in_rs = 32'h0000_1234; in_rt = 32'h0000_0F00;
        @(negedge clk);
        check(ready == 1'b1, "R8 ready between short ops", {63'b0, ready}, 64'd1);
        in_rs = 32'hFFFF_FF00; in_rt = 32'hFFFF_9000;
        @(negedge clk);
        in_valid = 1'b0;
        check(hilo() == model + pa, "R8 R4 first of pair", hilo(), model + pa);
        @(negedge clk);
        check(hilo() == model + pa + pb, "R8 R4 second of pair", hilo(), model + pa + pb);
        model = model + pa + pb;

        // R8 R7: back-to-back short low-word ops
        pa = ref_prod(1'b0, 32'hDEAD_BEEF, 32'h0000_00FF);
        pb = ref_prod(1'b0, 32'h0BAD_F00D, 32'h0000_1001);
        @(negedge clk);
        in_valid = 1'b1; in_op = 2'd3; in_signed = 1'b0; in_rs = 32'hDEAD_BEEF; in_rt = 32'h0000_00FF;
        @(negedge clk);
        in_rs = 32'h0BAD_F00D; in_rt = 32'h0000_1001;
        @(negedge clk);
        in_valid = 1'b0;
        check(res_valid == 1'b0, "R7 pair not yet out", {63'b0, res_valid}, 64'd0);
        @(negedge clk);
        check(res_valid && res_lo == pa[31:0], "R7 pair first", {31'b0, res_valid, res_lo}, {31'b0, 1'b1, pa[31:0]});
        @(negedge clk);
        check(res_valid && res_lo == pb[31:0], "R7 pair second", {31'b0, res_valid, res_lo}, {31'b0, 1'b1, pb[31:0]});
        @(negedge clk);
        check(res_valid == 1'b0, "R7 pair ends", {63'b0, res_valid}, 64'd0);

        // R9: request during the busy cycle is dropped
        pa = ref_prod(1'b0, 32'h0000_0321, 32'h1234_5678);
        in_valid = 1'b1; in_op = 2'd0; in_signed = 1'b0; in_rs = 32'h0000_0321; in_rt = 32'h1234_5678;
        @(negedge clk);
        check(ready == 1'b0, "R9 busy after long issue", {63'b0, ready}, 64'd0);
        in_op = 2'd1; in_rs = 32'h0000_0003; in_rt = 32'h0000_0005;
        @(negedge clk);
        in_valid = 1'b0;
        check(hilo() == model, "R9 not yet committed", hilo(), model);
        @(negedge clk);
        check(hilo() == pa, "R9 long load", hilo(), pa);
        repeat (4) @(negedge clk);
        check(hilo() == pa, "R9 dropped request had no effect", hilo(), pa);
        model = pa;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule